// File: doc/BRIEF.md
# ADC Control Register Front End and Conversion Sequencer

This block sits between a byte-wide register bus and a 10-bit successive-approximation converter. Software programs two 8-bit registers. The channel register selects the reference, the result justification and the input channel. The control register enables the block, starts conversions, arms automatic triggering, holds the completion flag, masks the interrupt and picks the converter clock divisor. Two further read-only addresses return the latched result as a high byte and a low byte.

The converter itself is outside the block. It sees a clock-enable pulse train taken from the system clock through the prescaler, a one-cycle start pulse, the selected reference and channel codes, and it answers with a one-cycle done pulse and a 10-bit value. A conversion starts in one of two ways: software writes the start bit, or, with auto-trigger armed, a rising edge arrives on the trigger input. When the done pulse arrives, the result bytes are captured, the flag is set and an interrupt is raised if it is enabled.

Top module: `adc_ctl_seq`

## Requirements
- R1: Register addresses are 0 = channel, 1 = control, 2 = result high, 3 = result low. While control bit 7 (enable) is 0, no conversion starts and `conv_tick` stays low.
- R2: Writing control with bit 7 and bit 6 both set starts one conversion. Bit 6 reads 1 from that write until the result is latched, and reads 0 afterwards.
- R3: With control bits 7 and 5 set, a rising edge on `trig_in` starts a conversion. With bit 5 clear, an edge on `trig_in` starts nothing.
- R4: On the done pulse of a running conversion, control bit 4 (flag) becomes 1 in the same cycle that both result bytes are updated.
- R5: `irq` is 1 exactly while control bit 4 and control bit 3 are both 1.
- R6: Control bits 2:0 = k (k from 1 to 7) make `conv_tick` pulse once every 2^k system clocks.
- R7: Prescaler code 000 acts as divide-by-2.
- R8: Channel bits 7:6 drive `ref_sel` directly (00 external pin, 01 supply, 10 reserved, 11 internal fixed).
- R9: With channel bit 5 = 1, the high byte holds result bits 9:2 and low byte bits 7:6 hold result bits 1:0. With bit 5 = 0, high byte bits 1:0 hold result bits 9:8 and the low byte holds bits 7:0. All other bits read 0.
- R10: Channel bits 4:0 drive `chan_code`, and codes 0 to 7 select single-ended inputs 0 to 7.
- R11: A start request (software or trigger) made while a conversion runs is ignored: no second `conv_start` pulse is issued.
- R12: Writing control with bit 4 = 1 clears the flag. Writing 0 to bit 4 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| trig_in | input | 1 | External auto-trigger source |
| conv_tick | output | 1 | Converter clock enable, one system cycle wide |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 10 | Conversion value, valid with conv_done |
| ref_sel | output | 2 | Reference selection to the analog side |
| chan_code | output | 5 | Input channel selection |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The hardest case to reach is a second start request that arrives while a conversion is already running. Under a fast divisor the window for it lasts only a few cycles. The stimulus picks the slowest divisor, so a conversion stays busy for hundreds of cycles. Inside that window it issues both a software start write and a trigger edge with auto-trigger armed, then counts `conv_start` pulses at the port and reads the busy bit back. The divisor sweep covers every code, including the reserved one, and measures the spacing between ticks at the port.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

   typedef enum logic [1:0] {
      RA_CHAN = 2'd0,
      RA_CTRL = 2'd1,
      RA_RHI  = 2'd2,
      RA_RLO  = 2'd3
   } reg_addr_e;

   // control register bit positions
   localparam int unsigned CB_EN   = 7;
   localparam int unsigned CB_SC   = 6;
   localparam int unsigned CB_ATE  = 5;
   localparam int unsigned CB_FLAG = 4;
   localparam int unsigned CB_IE   = 3;

   // channel register bit positions
   localparam int unsigned CH_LEFT = 5;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
   parameter int unsigned PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [PS_W-1:0] code,
   output logic            tick
);
   localparam int unsigned CNT_W = (1 << PS_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("adc_prescaler: PS_W out of range");
   end

   // code 0 is reserved and falls back to the smallest divisor
   always_comb begin
      if (code == '0) lim = CNT_W'(1);
      else            lim = (CNT_W'(1) << code) - CNT_W'(1);
   end

   // >= lets the counter recover when the divisor shrinks mid-count
   assign tick = en && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!en || tick)   cnt_q <= '0;
      else                    cnt_q <= cnt_q + CNT_W'(1);
   end

   // R6/R7: the smallest divisor is 2, so ticks never come back to back
   a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter bit SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic rise
);
   logic lvl;
   logic lvl_d;

   if (SYNC) begin : g_sync
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else begin
            s1_q <= trig;
            s2_q <= s1_q;
         end
      end
      assign lvl = s2_q;
   end else begin : g_direct
      assign lvl = trig;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign rise = lvl && !lvl_d;

endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              left,
   output logic [BYTE_W-1:0] hi,
   output logic [BYTE_W-1:0] lo
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAD_W  = PAIR_W - DATA_W;

   logic [PAIR_W-1:0] pair;

   if (DATA_W <= BYTE_W || DATA_W > PAIR_W) begin : g_bad_w
      $error("adc_result_pack: DATA_W must lie between BYTE_W+1 and 2*BYTE_W");
   end

   always_comb begin
      if (left) pair = {data, {PAD_W{1'b0}}};
      else      pair = {{PAD_W{1'b0}}, data};
   end

   assign hi = pair[PAIR_W-1:BYTE_W];
   assign lo = pair[BYTE_W-1:0];

   // R9: the padding bits of the pair are always zero
   always_comb begin
      if (left) a_r9_left_pad: assert (lo[PAD_W-1:0] == '0);
      else      a_r9_right_pad: assert (hi[BYTE_W-1:DATA_W-BYTE_W] == '0);
   end

endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
   import adc_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 10,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned PS_W      = 3,
   parameter int unsigned REF_W     = 2,
   parameter int unsigned MUX_W     = 5,
   parameter bit          SYNC_TRIG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              trig_in,
   output logic              conv_tick,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic [REF_W-1:0]  ref_sel,
   output logic [MUX_W-1:0]  chan_code,
   output logic              irq
);
   localparam int unsigned REF_LSB = BYTE_W - REF_W;

   if (REF_W + 1 + MUX_W != BYTE_W) begin : g_bad_chan
      $error("adc_ctl_seq: channel fields must fill one byte");
   end
   if (PS_W + 5 != BYTE_W) begin : g_bad_ctrl
      $error("adc_ctl_seq: control fields must fill one byte");
   end

   logic [BYTE_W-1:0] chan_q;
   logic              en_q, busy_q, ate_q, flag_q, ie_q;
   logic [PS_W-1:0]   ps_q;
   logic [BYTE_W-1:0] rhi_q, rlo_q;
   logic [BYTE_W-1:0] pk_hi, pk_lo;
   logic              wr_chan, wr_ctrl;
   logic              trig_rise, sw_req, hw_req, kill, finish;

   assign wr_chan = bus_wr && (bus_addr == RA_CHAN);
   assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);

   adc_trig_edge #(.SYNC(SYNC_TRIG)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig(trig_in), .rise(trig_rise));

   adc_prescaler #(.PS_W(PS_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .en(en_q), .code(ps_q), .tick(conv_tick));

   adc_result_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
      .data(conv_data), .left(chan_q[CH_LEFT]), .hi(pk_hi), .lo(pk_lo));

   // a write that turns the block off blocks any start in the same cycle
   assign kill   = wr_ctrl && !bus_wdata[CB_EN];
   assign sw_req = wr_ctrl && bus_wdata[CB_SC] && bus_wdata[CB_EN];
   assign hw_req = en_q && ate_q && trig_rise;
   assign conv_start = (sw_req || hw_req) && !busy_q && !kill;
   assign finish = busy_q && conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q <= '0;
         en_q   <= 1'b0;
         ate_q  <= 1'b0;
         ie_q   <= 1'b0;
         ps_q   <= '0;
      end else begin
         if (wr_chan) chan_q <= bus_wdata;
         if (wr_ctrl) begin
            en_q  <= bus_wdata[CB_EN];
            ate_q <= bus_wdata[CB_ATE];
            ie_q  <= bus_wdata[CB_IE];
            ps_q  <= bus_wdata[PS_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         flag_q <= 1'b0;
         rhi_q  <= '0;
         rlo_q  <= '0;
      end else begin
         if (conv_start)              busy_q <= 1'b1;
         else if (finish || !en_q)    busy_q <= 1'b0;

         // completion wins over a clear in the same cycle
         if (finish)                                flag_q <= 1'b1;
         else if (wr_ctrl && bus_wdata[CB_FLAG])    flag_q <= 1'b0;

         if (finish) begin
            rhi_q <= pk_hi;
            rlo_q <= pk_lo;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         RA_CHAN: bus_rdata = chan_q;
         RA_CTRL: bus_rdata = {en_q, busy_q, ate_q, flag_q, ie_q, ps_q};
         RA_RHI:  bus_rdata = rhi_q;
         default: bus_rdata = rlo_q;
      endcase
   end

   assign ref_sel   = chan_q[BYTE_W-1:REF_LSB];
   assign chan_code = chan_q[MUX_W-1:0];
   assign irq       = flag_q && ie_q;

   // R1: a disabled block never clocks the converter
   a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !conv_tick);

   // R2: an issued start leaves the block busy
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> busy_q);

   // R11: no second start while a conversion runs
   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !conv_start);

   // R4: completion raises the flag and loads the result pair
   a_r4_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (flag_q && rhi_q == $past(pk_hi) && rlo_q == $past(pk_lo)));

endmodule

// File: tb/sim_adc_ctl_seq.sv
module sim_adc_ctl_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       trig_in = 1'b0;
   logic       conv_tick, conv_start, irq;
   logic       conv_done;
   logic [9:0] conv_data;
   logic [1:0] ref_sel;
   logic [4:0] chan_code;

   int errors = 0;
   int checks = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   adc_ctl_seq u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
      .conv_tick(conv_tick), .conv_start(conv_start), .conv_done(conv_done),
      .conv_data(conv_data), .ref_sel(ref_sel), .chan_code(chan_code), .irq(irq));

   // behavioural converter: finishes after two converter clocks
   logic [9:0] stub_val = 10'd0;
   logic       s_busy = 1'b0;
   logic [1:0] s_cnt = 2'd0;
   logic       s_done = 1'b0;
   logic [9:0] s_data = 10'd0;
   assign conv_done = s_done;
   assign conv_data = s_data;
   always @(posedge clk) begin
      s_done <= 1'b0;
      if (conv_start) begin
         s_busy <= 1'b1;
         s_cnt  <= 2'd2;
      end else if (s_busy && conv_tick) begin
         if (s_cnt == 2'd1) begin
            s_busy <= 1'b0;
            s_done <= 1'b1;
            s_data <= stub_val;
         end
         s_cnt <= s_cnt - 2'd1;
      end
   end

   int n_start = 0;
   always @(posedge clk) if (conv_start) n_start++;

   int cyc = 0, last_tick = 0, gap = 0, n_tick = 0;
   always @(negedge clk) begin
      cyc++;
      if (conv_tick) begin
         n_tick++;
         gap = cyc - last_tick;
         last_tick = cyc;
      end
   end

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      summary();
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   // wait until the busy bit (control bit 6) reads 0
   task automatic wait_idle();
      logic [7:0] v;
      for (int i = 0; i < 2000; i++) begin
         rd(2'd1, v);
         if (!v[6]) break;
      end
   endtask

   initial begin
      logic [7:0] v, hi, lo;
      int s0;
      int vals [6] = '{10'h000, 10'h3FF, 10'h2A5, 10'h15A, 10'h201, 10'h0FE};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(2'd1, v); chk(v == 8'h00, "reset ctrl", v, 0);
      rd(2'd0, v); chk(v == 8'h00, "reset chan", v, 0);
      chk(irq == 1'b0, "reset irq", irq, 0);

      // R1: disabled block ignores start and keeps the converter clock idle
      s0 = n_start;
      wr(2'd1, 8'h41);
      repeat (40) @(negedge clk);
      chk(n_start == s0, "R1 no start when off", n_start - s0, 0);
      chk(n_tick == 0, "R1 no tick when off", n_tick, 0);
      rd(2'd1, v); chk(v[6] == 1'b0, "R1 busy bit off", v[6], 0);

      // R6 / R7: divisor sweep over every code
      for (int k = 0; k < 8; k++) begin
         int div;
         div = (k == 0) ? 2 : (1 << k);
         wr(2'd1, 8'h80 | k[7:0]);
         repeat (3 * div + 6) @(negedge clk);
         if (k == 0) chk(gap == div, "R7 reserved code /2", gap, div);
         else        chk(gap == div, "R6 divisor", gap, div);
      end

      // R8 / R10: reference and channel outputs
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 8; c++) begin
            wr(2'd0, {r[1:0], 1'b0, c[4:0]});
            chk(ref_sel == r[1:0], "R8 ref_sel", ref_sel, r);
            chk(chan_code == c[4:0], "R10 chan_code", chan_code, c);
         end
      end

      // R2 / R4 / R9: software starts, both justifications
      for (int j = 0; j < 2; j++) begin
         for (int i = 0; i < 6; i++) begin
            int eh, el;
            stub_val = vals[i][9:0];
            wr(2'd0, {2'b01, j[0], 5'd3});
            wr(2'd1, 8'hD1);
            rd(2'd1, v); chk(v[6] == 1'b1, "R2 busy after start", v[6], 1);
            wait_idle();
            rd(2'd1, v); chk(v == 8'h91, "R4 flag set, busy clear", v, 8'h91);
            if (j == 1) begin
               eh = vals[i] >> 2; el = (vals[i] & 3) << 6;
            end else begin
               eh = vals[i] >> 8; el = vals[i] & 255;
            end
            rd(2'd2, hi); chk(hi == eh[7:0], "R9 high byte", hi, eh);
            rd(2'd3, lo); chk(lo == el[7:0], "R9 low byte", lo, el);
         end
      end

      // R5 / R12: interrupt follows flag and enable; flag clears on write-one
      chk(irq == 1'b0, "R5 irq masked", irq, 0);
      wr(2'd1, 8'h89);
      chk(irq == 1'b1, "R5 irq raised", irq, 1);
      rd(2'd1, v); chk(v[4] == 1'b1, "R12 write zero keeps flag", v[4], 1);
      wr(2'd1, 8'h99);
      chk(irq == 1'b0, "R5 irq drops with flag", irq, 0);
      rd(2'd1, v); chk(v[4] == 1'b0, "R12 flag cleared", v[4], 0);

      // R3: trigger without auto-trigger does nothing
      s0 = n_start;
      trig_in = 1'b1; repeat (6) @(negedge clk); trig_in = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_start == s0, "R3 trigger ignored when unarmed", n_start - s0, 0);

      // R3: trigger with auto-trigger armed
      stub_val = 10'h155;
      wr(2'd0, 8'h20);
      wr(2'd1, 8'hA1);
      trig_in = 1'b1; repeat (6) @(negedge clk); trig_in = 1'b0;
      wait_idle();
      chk(n_start == s0 + 1, "R3 trigger starts", n_start - s0, 1);
      rd(2'd2, hi); chk(hi == 8'h55, "R3 triggered result", hi, 8'h55);

      // R11: start requests while busy, slowest divisor
      wr(2'd1, 8'hB7);
      s0 = n_start;
      wr(2'd1, 8'hE7);
      repeat (10) @(negedge clk);
      wr(2'd1, 8'hE7);
      trig_in = 1'b1; repeat (6) @(negedge clk); trig_in = 1'b0;
      rd(2'd1, v); chk(v[6] == 1'b1, "R11 still busy", v[6], 1);
      wait_idle();
      chk(n_start == s0 + 1, "R11 one start only", n_start - s0, 1);

      summary();
   end
endmodule